// File: doc/BRIEF.md
# Oversampling Serial Receiver with Programmable Divisor

This block receives asynchronous serial characters on a pin that is not synchronous to the system clock. Each character is a low start bit, eight data bits with the least significant bit first, and a high stop bit, with no parity. While idle the line rests high. The pin first passes through a two-stage flip-flop synchronizer. A down-counter divides the system clock by a 16-bit divisor that software can rewrite at any time, and produces a one-clock sampling tick at sixteen times the bit rate. The bit rate therefore stays fixed when the system clock changes, as long as the divisor is changed to match. For example, 9600 bit/s needs a divisor of 33 at 5 MHz and 130 at 20 MHz, and 4800 bit/s needs 65 and 260.

The receiver looks for a low level on sampling ticks. It checks the line again at the middle of the start bit. It then samples each data bit and the stop bit at intervals of sixteen ticks. A finished character goes into a one-entry buffer and raises an available flag, which stays set until the processor pulses a read strobe. If the stop bit samples low, a framing-error flag is raised alongside the stored character.

Top module: `oversamp_rx`

## Requirements
- R1: After reset, `rx_avail` is 0, `rx_err` is 0 and `rx_byte` is 0x00.
- R2: A character sent at a bit period of 16 × divisor clocks, with the start bit low, then data bits 0 to 7 in that order, then the stop bit high, appears on `rx_byte` with bit 0 equal to the first data bit. This holds for several divisor values.
- R3: `rx_avail` rises only when a character is stored, and then stays at 1 until a read strobe.
- R4: A one-clock pulse on `rd_stb` while no character is being stored clears `rx_avail` on the next clock. `rx_byte` does not change.
- R5: A second character that arrives before a read replaces `rx_byte`, and `rx_avail` stays at 1.
- R6: A character whose stop bit samples low is still stored and sets `rx_err` to 1. The next character with a high stop bit clears `rx_err` to 0. `rx_err` and `rx_byte` change only when a character is stored.
- R7: A low pulse on `rxd` shorter than half a bit period is rejected at the mid-start re-check. No character is stored, and `rx_avail` and `rx_byte` keep their values.
- R8: The sampling tick repeats every max(divisor, 1) clocks. A divisor write restarts the count, so that the next tick comes max(new divisor, 1) clocks after the write. A divisor of 0 behaves like 1.
- R9: A divisor write changes the bit rate at which later characters are received.
- R10: The serial input reaches the receive logic only through two synchronizing flip-flops, so the internal line equals `rxd` delayed by two clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_wr | input | 1 | Divisor write strobe |
| div_val | input | 16 | New divisor value |
| rxd | input | 1 | Asynchronous serial input, idle high |
| rd_stb | input | 1 | Processor read strobe, clears `rx_avail` |
| rx_byte | output | 8 | Last stored character |
| rx_avail | output | 1 | A character is waiting to be read |
| rx_err | output | 1 | The stop bit of the stored character sampled low |

## Verification
The hardest case to reach from the ports is the abort at the mid-start re-check. The low pulse has to outlast the synchronizer and at least one sampling tick, and it has to end before the eighth tick after detection. The bench holds the line low for three tick periods at the current divisor, so the pulse falls clearly inside that window. It then sends a real character to show that the receiver went back to hunting for a start bit. A frame with a low stop bit leaves the line low after the stop sample, which starts a false start detection. That detection has to fail the mid-start re-check and must not produce a stray character.

// File: rtl/oversamp_rx_pkg.sv
package oversamp_rx_pkg;
  localparam int DIV_W    = 16;
  localparam int OVS      = 16;
  localparam int PH_W     = $clog2(OVS);
  localparam int DATA_W   = 8;
  localparam int IDX_W    = $clog2(DATA_W);

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  // Counter reload value for a divisor; zero is treated as one.
  function automatic logic [DIV_W-1:0] reload_of(input logic [DIV_W-1:0] d);
    return (d == '0) ? '0 : d - 1'b1;
  endfunction
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int   STAGES = 2,
  parameter logic RST_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_LVL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rx_tick_gen.sv
module rx_tick_gen
  import oversamp_rx_pkg::*;
#(
  parameter logic [DIV_W-1:0] DEF_DIV = 16'd33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [DIV_W-1:0] wdata,
  output logic             tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DEF_DIV;
      cnt   <= reload_of(DEF_DIV);
    end else if (wr) begin
      div_q <= wdata;
      cnt   <= reload_of(wdata);
    end else if (cnt == '0) begin
      cnt   <= reload_of(div_q);
    end else begin
      cnt   <= cnt - 1'b1;
    end
  end

  assign tick = (cnt == '0);
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import oversamp_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  output logic              start_seen,
  output logic              glitch_abort,
  output logic              bit_sample,
  output logic              byte_done,
  output logic [DATA_W-1:0] shreg
);
  localparam logic [PH_W-1:0]  HALF_M1 = PH_W'(OVS/2 - 1);
  localparam logic [PH_W-1:0]  FULL_M1 = PH_W'(OVS - 1);
  localparam logic [IDX_W-1:0] LAST    = IDX_W'(DATA_W - 1);

  rx_state_e        st;
  logic [PH_W-1:0]  ph;
  logic [IDX_W-1:0] idx;
  logic             mid_start;

  assign start_seen   = tick && (st == RX_IDLE) && !line;
  assign mid_start    = tick && (st == RX_START) && (ph == HALF_M1);
  assign glitch_abort = mid_start && line;
  assign bit_sample   = tick && ((st == RX_DATA) || (st == RX_STOP)) && (ph == FULL_M1);
  assign byte_done    = bit_sample && (st == RX_STOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= RX_IDLE;
      ph    <= '0;
      idx   <= '0;
      shreg <= '0;
    end else begin
      case (st)
        RX_IDLE: begin
          if (start_seen) begin
            st <= RX_START;
            ph <= '0;
          end
        end
        RX_START: begin
          if (mid_start) begin
            st  <= line ? RX_IDLE : RX_DATA;
            ph  <= '0;
            idx <= '0;
          end else if (tick) begin
            ph <= ph + 1'b1;
          end
        end
        RX_DATA: begin
          if (bit_sample) begin
            shreg <= {line, shreg[DATA_W-1:1]};
            ph    <= '0;
            if (idx == LAST) st <= RX_STOP;
            else             idx <= idx + 1'b1;
          end else if (tick) begin
            ph <= ph + 1'b1;
          end
        end
        RX_STOP: begin
          if (bit_sample) begin
            st <= RX_IDLE;
            ph <= '0;
          end else if (tick) begin
            ph <= ph + 1'b1;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/oversamp_rx.sv
module oversamp_rx
  import oversamp_rx_pkg::*;
#(
  parameter logic [15:0] DEF_DIV = 16'd33
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        div_wr,
  input  logic [15:0] div_val,
  input  logic        rxd,
  input  logic        rd_stb,
  output logic [7:0]  rx_byte,
  output logic        rx_avail,
  output logic        rx_err
);
  logic              line_s;
  logic              tick_w;
  logic              start_seen_w;
  logic              glitch_abort_w;
  logic              bit_sample_w;
  logic              byte_done_w;
  logic [DATA_W-1:0] shreg_w;

  rx_sync #(.STAGES(2), .RST_LVL(1'b1)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(line_s)
  );

  rx_tick_gen #(.DEF_DIV(DEF_DIV)) i_tick (
    .clk(clk), .rst_n(rst_n), .wr(div_wr), .wdata(div_val), .tick(tick_w)
  );

  rx_frame i_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .line(line_s),
    .start_seen(start_seen_w), .glitch_abort(glitch_abort_w),
    .bit_sample(bit_sample_w), .byte_done(byte_done_w), .shreg(shreg_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte  <= '0;
      rx_avail <= 1'b0;
      rx_err   <= 1'b0;
    end else if (byte_done_w) begin
      rx_byte  <= shreg_w;
      rx_avail <= 1'b1;
      rx_err   <= !line_s;
    end else if (rd_stb) begin
      rx_avail <= 1'b0;
    end
  end
endmodule

// File: rtl/oversamp_rx_chk.sv
module oversamp_rx_chk #(
  parameter logic [15:0] DEF_DIV = 16'd33
) (
  input logic        clk,
  input logic        rst_n,
  input logic        div_wr,
  input logic [15:0] div_val,
  input logic        rxd,
  input logic        rd_stb,
  input logic [7:0]  rx_byte,
  input logic        rx_avail,
  input logic        rx_err,
  input logic        line_s,
  input logic        tick,
  input logic        start_seen,
  input logic        glitch_abort,
  input logic        byte_done
);
  logic [16:0] gap;
  logic [15:0] eff;
  logic [16:0] eff_div;
  logic [1:0]  age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap <= '0;
      eff <= DEF_DIV;
      age <= '0;
    end else begin
      gap <= (tick || div_wr) ? 17'd0 : gap + 17'd1;
      if (div_wr) eff <= div_val;
      if (age != 2'd3) age <= age + 2'd1;
    end
  end

  assign eff_div = (eff == 16'd0) ? 17'd1 : {1'b0, eff};

  // R8
  tick_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (gap + 17'd1 == eff_div));

  // R3
  avail_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_avail) |-> $past(byte_done));

  // R4
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !byte_done) |=> !rx_avail);

  // R6
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_done |=> ($stable(rx_err) && $stable(rx_byte)));

  // R7
  event_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_seen, glitch_abort, byte_done}));

  // R10
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (line_s == $past(rxd, 2)));
endmodule

bind oversamp_rx oversamp_rx_chk #(.DEF_DIV(DEF_DIV)) i_chk (
  .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_val(div_val), .rxd(rxd),
  .rd_stb(rd_stb), .rx_byte(rx_byte), .rx_avail(rx_avail), .rx_err(rx_err),
  .line_s(line_s), .tick(tick_w), .start_seen(start_seen_w),
  .glitch_abort(glitch_abort_w), .byte_done(byte_done_w)
);

// File: tb/test_oversamp_rx.sv
`timescale 1ns/1ps
module test_oversamp_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        div_wr = 1'b0;
  logic [15:0] div_val = 16'd0;
  logic        rxd = 1'b1;
  logic        rd_stb = 1'b0;
  logic [7:0]  rx_byte;
  logic        rx_avail;
  logic        rx_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  oversamp_rx i_oversamp_rx (
    .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_val(div_val), .rxd(rxd),
    .rd_stb(rd_stb), .rx_byte(rx_byte), .rx_avail(rx_avail), .rx_err(rx_err)
  );

  // vector: {divisor, data, stop level}
  localparam int NV = 8;
  localparam logic [24:0] VEC [NV] = '{
    {16'd4,   8'hA5, 1'b1},
    {16'd5,   8'h3C, 1'b1},
    {16'd7,   8'h01, 1'b1},
    {16'd13,  8'h80, 1'b1},
    {16'd3,   8'h5E, 1'b0},
    {16'd33,  8'hFF, 1'b1},
    {16'd130, 8'h00, 1'b1},
    {16'd2,   8'hC3, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_div(input logic [15:0] d);
    @(negedge clk);
    div_wr = 1'b1;
    div_val = d;
    @(negedge clk);
    div_wr = 1'b0;
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int d, input logic [7:0] b, input logic stop);
    int bp;
    bp = 16 * ((d == 0) ? 1 : d);
    rxd = 1'b0;
    hold(bp);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      hold(bp);
    end
    rxd = stop;
    hold(bp);
    rxd = 1'b1;
    hold(2 * bp);
  endtask

  task automatic do_read();
    @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  initial begin
    hold(3);
    // R1: reset values
    check("R1 avail", rx_avail, 0);
    check("R1 err", rx_err, 0);
    check("R1 byte", rx_byte, 0);
    rst_n = 1'b1;
    hold(3);

    // R2 R9 R10: table walk over divisors, read after each
    for (int v = 0; v < NV; v++) begin
      write_div(VEC[v][24:9]);
      hold(5);
      send(int'(VEC[v][24:9]), VEC[v][8:1], VEC[v][0]);
      check("R2 byte", rx_byte, VEC[v][8:1]);
      check("R3 avail", rx_avail, 1);
      check("R6 err", rx_err, VEC[v][0] ? 0 : 1);
      do_read();
      check("R4 avail cleared", rx_avail, 0);
      check("R4 byte kept", rx_byte, VEC[v][8:1]);
    end

    // R3: flag stays set without a read
    write_div(16'd4);
    send(4, 8'h69, 1'b1);
    hold(200);
    check("R3 avail held", rx_avail, 1);
    // R5: overwrite before read
    send(4, 8'h96, 1'b1);
    check("R5 byte", rx_byte, 8'h96);
    check("R5 avail", rx_avail, 1);
    do_read();

    // R7: short glitch rejected
    rxd = 1'b0;
    hold(3 * 4);
    rxd = 1'b1;
    hold(2 * 16 * 4);
    check("R7 avail", rx_avail, 0);
    check("R7 byte", rx_byte, 8'h96);
    send(4, 8'h2D, 1'b1);
    check("R7 next byte", rx_byte, 8'h2D);
    do_read();

    // R6: error set, then cleared by a good frame
    send(4, 8'h11, 1'b0);
    check("R6 err set", rx_err, 1);
    check("R6 byte stored", rx_byte, 8'h11);
    send(4, 8'h22, 1'b1);
    check("R6 err cleared", rx_err, 0);
    do_read();

    // R8: divisor 0 behaves as 1
    write_div(16'd0);
    hold(4);
    send(0, 8'hB7, 1'b1);
    check("R8 div0 byte", rx_byte, 8'hB7);
    do_read();

    // R9: rate change mid-idle, old rate would misread
    write_div(16'd9);
    send(9, 8'h4E, 1'b1);
    check("R9 new rate", rx_byte, 8'h4E);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule